// File: doc/BRIEF.md
# PCI Host Bridge Register and Window Translator

This block sits between a processor-side request stream and a downstream bus port. It answers three address regions: a small control region, a 16 MiB memory window and a 256 KiB I/O window. Each region can be reached at two physical bases, and both bases behave the same. The control region holds the bridge's own 256-byte configuration header and a configuration address register. It also holds two relocation base registers, one for the memory window and one for the I/O window, and a configuration data port. Each access to the data port becomes one configuration cycle on the downstream port, aimed at the address held in the configuration address register.

Memory and I/O window accesses are forwarded downstream. Their address is the offset into the window plus the matching base register. Byte enables and data lanes come from the low address bits and the access size. Write data travels right-aligned on the upstream side and lane-aligned on the downstream side. Read data returns the other way round.

The upstream request is valid/ready. A request is taken on a clock edge where `up_valid` and `up_ready` are both high, and `up_ready` stays low from that edge until the answer has been taken. The answer is also valid/ready: `rsp_valid` and `rsp_rdata` hold steady until a clock edge with `rsp_ready` high, and the consumer may hold `rsp_ready` low as long as it likes. On the downstream side, `dn_req` and all of its fields stay stable until the edge on which `dn_ack` is high. `dn_rdata` is captured on that same edge. Only one request is ever in flight.

Top module: `pcib_bridge`

## Requirements
- R1: Control offsets 0x000 to 0x0FC hold the 64-word header, read and written as 32-bit little-endian words: byte offset k sits in bits 8*(k%4)+7:8*(k%4). After reset, the word at 0x000 is {DEVICE_ID, VENDOR_ID} and the word at 0x004 is 0x02900080.
- R2: Control offset 0x1C0 is the configuration address register. A 32-bit write sets it and a 32-bit read returns it.
- R3: Control offsets 0x1C4 (memory base) and 0x1C8 (I/O base) accept writes, and a read of either returns zero.
- R4: A 32-bit write to control offset 0x220 issues one downstream configuration write. It has type code 0, the configuration address register as its address, size 4, byte enables 0xF and the written data. The answer carries zero.
- R5: A 32-bit read of control offset 0x220 issues one downstream configuration read at the configuration address register, and returns the downstream data.
- R6: A control-region access of size 1 or 2, or at any offset not listed in R1 to R5, changes no state, issues no downstream cycle, and answers zero.
- R7: An access of size 1, 2 or 4 to the memory window becomes a downstream cycle with type code 1, at the window offset plus the memory base.
- R8: An access of size 1, 2 or 4 to the I/O window becomes a downstream cycle with type code 2, at the window offset plus the I/O base.
- R9: The control region (0x224 bytes) answers at 0x1E200000 and 0xFE200000, the I/O window at 0x1E240000 and 0xFE240000, and the memory window at 0x1D000000 and 0xFD000000, with identical behaviour at each pair.
- R10: Let a be the low two bits of the downstream address. Size 1 gives byte enable 1<<a. Size 2 gives 0x3<<(2*a[1]). Size 4 gives 0xF. Write data is shifted up to the enabled lanes. Read data is shifted down from them and zero-filled above the access size.
- R11: After reset `up_ready` is high and `rsp_valid` and `dn_req` are low. At most one downstream request is outstanding. Its fields hold until it is acknowledged, and `up_ready` stays low until the answer has been taken under back-pressure.
- R12: An address outside every region, or a size code other than 1, 2 or 4, answers zero, issues no downstream cycle and changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Upstream request valid |
| up_ready | output | 1 | Bridge can take a request |
| up_write | input | 1 | 1 = write, 0 = read |
| up_addr | input | 32 | Upstream physical address |
| up_size | input | 3 | Access size in bytes (1, 2, 4) |
| up_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Answer valid |
| rsp_ready | input | 1 | Answer taken |
| rsp_rdata | output | 32 | Read data, right-aligned (zero for writes) |
| dn_req | output | 1 | Downstream request |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_type | output | 2 | Cycle type: 0 config, 1 memory, 2 I/O |
| dn_write | output | 1 | Downstream write |
| dn_addr | output | 32 | Downstream address |
| dn_size | output | 3 | Downstream size in bytes |
| dn_be | output | 4 | Byte enables |
| dn_wdata | output | 32 | Lane-aligned write data |
| dn_rdata | input | 32 | Lane-aligned read data, valid with dn_ack |

## Verification
The bench builds the bridge with VENDOR_ID = 0xC0DE and DEVICE_ID = 0x7A51, so the reset value of header word 0 can be told apart from any default. All alias bases, window spans and the header size keep their default values. With those defaults, one access each reaches the last word of both windows, the first byte past each region, and the same register through either alias. A downstream responder acknowledges after a delay that varies, and the answer consumer throttles `rsp_ready`, so the stall and hold rules are exercised with waits of several lengths.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  // Data path width is fixed at one 32-bit word with four byte lanes.
  localparam int unsigned DW = 32;

  // Size encodings carried on up_size / dn_size (bytes).
  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  // Control region offsets with behaviour attached.
  localparam logic [31:0] OFS_CADDR = 32'h0000_01C0;
  localparam logic [31:0] OFS_MBASE = 32'h0000_01C4;
  localparam logic [31:0] OFS_IBASE = 32'h0000_01C8;
  localparam logic [31:0] OFS_CPORT = 32'h0000_0220;

  typedef enum logic [1:0] {
    CYC_CFG = 2'd0,
    CYC_MEM = 2'd1,
    CYC_IO  = 2'd2
  } cyc_e;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_CTRL = 2'd1,
    RGN_MEM  = 2'd2,
    RGN_IO   = 2'd3
  } rgn_e;

endpackage

// File: rtl/pcib_decode.sv
module pcib_decode
  import pcib_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned NUM_ALIAS = 2,
  parameter logic [NUM_ALIAS*AW-1:0] CTRL_BASES = {32'hFE20_0000, 32'h1E20_0000},
  parameter logic [NUM_ALIAS*AW-1:0] MEM_BASES  = {32'hFD00_0000, 32'h1D00_0000},
  parameter logic [NUM_ALIAS*AW-1:0] IO_BASES   = {32'hFE24_0000, 32'h1E24_0000},
  parameter logic [AW-1:0] CTRL_SPAN = 32'h0000_0224,
  parameter logic [AW-1:0] MEM_SPAN  = 32'h0100_0000,
  parameter logic [AW-1:0] IO_SPAN   = 32'h0004_0000
)(
  input  logic [AW-1:0] addr,
  output rgn_e          rgn,
  output logic [AW-1:0] offset
);

  logic [NUM_ALIAS-1:0] ctrl_hit, mem_hit, io_hit;
  logic [AW-1:0] ctrl_ofs [NUM_ALIAS];
  logic [AW-1:0] mem_ofs  [NUM_ALIAS];
  logic [AW-1:0] io_ofs   [NUM_ALIAS];

  // One comparator set per alias; an unsigned difference below the span
  // means the address lies inside that copy of the region.
  for (genvar g = 0; g < NUM_ALIAS; g++) begin : g_alias
    assign ctrl_ofs[g] = addr - CTRL_BASES[g*AW +: AW];
    assign mem_ofs[g]  = addr - MEM_BASES[g*AW +: AW];
    assign io_ofs[g]   = addr - IO_BASES[g*AW +: AW];
    assign ctrl_hit[g] = ctrl_ofs[g] < CTRL_SPAN;
    assign mem_hit[g]  = mem_ofs[g] < MEM_SPAN;
    assign io_hit[g]   = io_ofs[g] < IO_SPAN;
  end

  always_comb begin
    rgn    = RGN_NONE;
    offset = '0;
    for (int i = 0; i < NUM_ALIAS; i++) begin
      if (ctrl_hit[i]) begin
        rgn    = RGN_CTRL;
        offset = ctrl_ofs[i];
      end else if (io_hit[i]) begin
        rgn    = RGN_IO;
        offset = io_ofs[i];
      end else if (mem_hit[i]) begin
        rgn    = RGN_MEM;
        offset = mem_ofs[i];
      end
    end
  end

endmodule

// File: rtl/pcib_cfg_hdr.sv
module pcib_cfg_hdr #(
  parameter int unsigned HDR_BYTES     = 256,
  parameter logic [15:0] VENDOR_ID     = 16'hFFFF,
  parameter logic [15:0] DEVICE_ID     = 16'hFFFF,
  parameter logic [31:0] CMD_STAT_INIT = 32'h0290_0080,
  localparam int unsigned WORDS = HDR_BYTES / 4,
  localparam int unsigned IW    = $clog2(WORDS)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] idx,
  input  logic [31:0]   wr_data,
  output logic [31:0]   rd_data
);

  logic [WORDS-1:0][31:0] words;

  // Each header word is its own register so that its reset value can be
  // chosen per position: identity in word 0, command/status in word 1.
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    localparam logic [31:0] INIT = (g == 0) ? {DEVICE_ID, VENDOR_ID} :
                                   (g == 1) ? CMD_STAT_INIT : 32'h0;
    logic [31:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= INIT;
      else if (wr_en && idx == IW'(g))     q <= wr_data;
    end
    assign words[g] = q;
  end

  assign rd_data = words[idx];

endmodule

// File: rtl/pcib_lane.sv
module pcib_lane
  import pcib_pkg::*;
#(
  localparam int unsigned NB = DW / 8
)(
  input  logic [1:0]    addr_lo,
  input  logic [2:0]    size,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] rdata_in,
  output logic [NB-1:0] be,
  output logic [DW-1:0] wdata_out,
  output logic [DW-1:0] rdata_out
);

  logic [1:0]    lane;
  logic [NB-1:0] bmask;
  logic [DW-1:0] dmask;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin lane = addr_lo;            bmask = 4'b0001; end
      SZ_HALF: begin lane = {addr_lo[1], 1'b0}; bmask = 4'b0011; end
      default: begin lane = 2'd0;               bmask = 4'b1111; end
    endcase
  end

  for (genvar b = 0; b < NB; b++) begin : g_dmask
    assign dmask[8*b +: 8] = {8{bmask[b]}};
  end

  assign be        = bmask << lane;
  assign wdata_out = wdata_in << {lane, 3'b000};
  assign rdata_out = (rdata_in >> {lane, 3'b000}) & dmask;

endmodule

// File: rtl/pcib_bridge.sv
module pcib_bridge
  import pcib_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned NUM_ALIAS = 2,
  parameter logic [NUM_ALIAS*AW-1:0] CTRL_BASES = {32'hFE20_0000, 32'h1E20_0000},
  parameter logic [NUM_ALIAS*AW-1:0] MEM_BASES  = {32'hFD00_0000, 32'h1D00_0000},
  parameter logic [NUM_ALIAS*AW-1:0] IO_BASES   = {32'hFE24_0000, 32'h1E24_0000},
  parameter logic [AW-1:0] CTRL_SPAN = 32'h0000_0224,
  parameter logic [AW-1:0] MEM_SPAN  = 32'h0100_0000,
  parameter logic [AW-1:0] IO_SPAN   = 32'h0004_0000,
  parameter int unsigned HDR_BYTES   = 256,
  parameter logic [15:0] VENDOR_ID   = 16'hFFFF,
  parameter logic [15:0] DEVICE_ID   = 16'hFFFF,
  parameter logic [31:0] CMD_STAT_INIT = 32'h0290_0080
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic          up_write,
  input  logic [AW-1:0] up_addr,
  input  logic [2:0]    up_size,
  input  logic [31:0]   up_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [31:0]   rsp_rdata,
  output logic          dn_req,
  input  logic          dn_ack,
  output logic [1:0]    dn_type,
  output logic          dn_write,
  output logic [AW-1:0] dn_addr,
  output logic [2:0]    dn_size,
  output logic [3:0]    dn_be,
  output logic [31:0]   dn_wdata,
  input  logic [31:0]   dn_rdata
);

  localparam int unsigned HDR_WORDS = HDR_BYTES / 4;
  localparam int unsigned HIW       = $clog2(HDR_WORDS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DOWN = 2'd1,
    ST_RESP = 2'd2
  } st_e;

  st_e           st_q;
  logic [AW-1:0] cfg_addr_q, mem_base_q, io_base_q;
  logic [1:0]    dn_type_q;
  logic          dn_write_q;
  logic [AW-1:0] dn_addr_q;
  logic [2:0]    dn_size_q;
  logic [DW-1:0] dn_wraw_q;
  logic [DW-1:0] rsp_q;

  // ---------------------------------------------------------------- decode
  rgn_e          rgn;
  logic [AW-1:0] ofs;

  pcib_decode #(
    .AW(AW), .NUM_ALIAS(NUM_ALIAS),
    .CTRL_BASES(CTRL_BASES), .MEM_BASES(MEM_BASES), .IO_BASES(IO_BASES),
    .CTRL_SPAN(CTRL_SPAN), .MEM_SPAN(MEM_SPAN), .IO_SPAN(IO_SPAN)
  ) u_dec (
    .addr   (up_addr),
    .rgn    (rgn),
    .offset (ofs)
  );

  logic size_ok, ctrl_word;
  logic hit_hdr, hit_caddr, hit_mbase, hit_ibase, hit_cport;

  assign size_ok   = (up_size == SZ_BYTE) || (up_size == SZ_HALF) || (up_size == SZ_WORD);
  // The control region only reacts to aligned whole-word accesses.
  assign ctrl_word = (rgn == RGN_CTRL) && (up_size == SZ_WORD) && (ofs[1:0] == 2'b00);
  assign hit_hdr   = ctrl_word && (ofs < AW'(HDR_BYTES));
  assign hit_caddr = ctrl_word && (ofs == AW'(OFS_CADDR));
  assign hit_mbase = ctrl_word && (ofs == AW'(OFS_MBASE));
  assign hit_ibase = ctrl_word && (ofs == AW'(OFS_IBASE));
  assign hit_cport = ctrl_word && (ofs == AW'(OFS_CPORT));

  // ---------------------------------------------------------------- header
  logic        hdr_we;
  logic [31:0] hdr_rd;

  assign hdr_we = up_valid && (st_q == ST_IDLE) && up_write && hit_hdr;

  pcib_cfg_hdr #(
    .HDR_BYTES(HDR_BYTES), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
    .CMD_STAT_INIT(CMD_STAT_INIT)
  ) u_hdr (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (hdr_we),
    .idx     (ofs[HIW+1:2]),
    .wr_data (up_wdata),
    .rd_data (hdr_rd)
  );

  // Local read value: base registers intentionally fall through to zero.
  logic [DW-1:0] local_rd;
  always_comb begin
    if (hit_hdr)        local_rd = hdr_rd;
    else if (hit_caddr) local_rd = DW'(cfg_addr_q);
    else                local_rd = '0;
  end

  // ---------------------------------------------------- forwarding choice
  logic          fwd;
  cyc_e          nxt_type;
  logic [AW-1:0] nxt_addr;
  logic [2:0]    nxt_size;

  always_comb begin
    fwd      = 1'b0;
    nxt_type = CYC_MEM;
    nxt_addr = ofs + mem_base_q;
    nxt_size = up_size;
    unique case (rgn)
      RGN_MEM: fwd = size_ok;
      RGN_IO: begin
        fwd      = size_ok;
        nxt_type = CYC_IO;
        nxt_addr = ofs + io_base_q;
      end
      RGN_CTRL: begin
        fwd      = hit_cport;
        nxt_type = CYC_CFG;
        nxt_addr = cfg_addr_q;
        nxt_size = SZ_WORD;
      end
      default: ;
    endcase
  end

  // ---------------------------------------------------------------- lanes
  logic [DW-1:0] lane_rd;

  pcib_lane u_lane (
    .addr_lo   (dn_addr_q[1:0]),
    .size      (dn_size_q),
    .wdata_in  (dn_wraw_q),
    .rdata_in  (dn_rdata),
    .be        (dn_be),
    .wdata_out (dn_wdata),
    .rdata_out (lane_rd)
  );

  // ------------------------------------------------------------ sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      cfg_addr_q <= '0;
      mem_base_q <= '0;
      io_base_q  <= '0;
      dn_type_q  <= '0;
      dn_write_q <= 1'b0;
      dn_addr_q  <= '0;
      dn_size_q  <= '0;
      dn_wraw_q  <= '0;
      rsp_q      <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (up_valid) begin
            if (fwd) begin
              dn_type_q  <= nxt_type;
              dn_write_q <= up_write;
              dn_addr_q  <= nxt_addr;
              dn_size_q  <= nxt_size;
              dn_wraw_q  <= up_wdata;
              st_q       <= ST_DOWN;
            end else begin
              rsp_q <= up_write ? '0 : local_rd;
              st_q  <= ST_RESP;
            end
            if (up_write && hit_caddr) cfg_addr_q <= AW'(up_wdata);
            if (up_write && hit_mbase) mem_base_q <= AW'(up_wdata);
            if (up_write && hit_ibase) io_base_q  <= AW'(up_wdata);
          end
        end
        ST_DOWN: begin
          if (dn_ack) begin
            rsp_q <= dn_write_q ? '0 : lane_rd;
            st_q  <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign up_ready  = (st_q == ST_IDLE);
  assign dn_req    = (st_q == ST_DOWN);
  assign rsp_valid = (st_q == ST_RESP);
  assign rsp_rdata = rsp_q;
  assign dn_type   = dn_type_q;
  assign dn_write  = dn_write_q;
  assign dn_addr   = dn_addr_q;
  assign dn_size   = dn_size_q;

  // ------------------------------------------------------------ assertions
  // R11
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_addr) && $stable(dn_be)
                          && $stable(dn_wdata) && $stable(dn_type) && $stable(dn_write));

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));

  // R11
  ack_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack |=> rsp_valid && !dn_req);

  // R4
  cfg_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_type == CYC_CFG |-> dn_be == 4'hF && dn_size == SZ_WORD);

  // R10
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> $countones(dn_be) == int'(dn_size));

endmodule

// File: tb/test_pcib_bridge.sv
`timescale 1ns/1ps
module test_pcib_bridge;

  localparam logic [15:0] VID = 16'hC0DE;
  localparam logic [15:0] DID = 16'h7A51;

  typedef struct packed {
    logic [1:0]  typ;
    logic        wr;
    logic [31:0] addr;
    logic [2:0]  size;
    logic [3:0]  be;
    logic [31:0] wdata;
  } dn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0, up_ready, up_write = 1'b0;
  logic [31:0] up_addr = '0, up_wdata = '0;
  logic [2:0]  up_size = 3'd4;
  logic rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic dn_req, dn_ack, dn_write;
  logic [1:0] dn_type;
  logic [31:0] dn_addr, dn_wdata, dn_rdata;
  logic [2:0] dn_size;
  logic [3:0] dn_be;

  always #2.5 clk = ~clk;

  pcib_bridge #(.VENDOR_ID(VID), .DEVICE_ID(DID)) i_pcib_bridge (
    .clk, .rst_n, .up_valid, .up_ready, .up_write, .up_addr, .up_size, .up_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata, .dn_req, .dn_ack, .dn_type, .dn_write,
    .dn_addr, .dn_size, .dn_be, .dn_wdata, .dn_rdata
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [31:0] rq[$];
  string       rtag[$];
  dn_t         dq[$];
  string       dtag[$];

  function automatic logic [31:0] pat(logic [31:0] a);
    return a ^ 32'h5A5A_A5A5;
  endfunction

  task automatic chk(bit ok, string tag, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expdn(logic [1:0] t, logic w, logic [31:0] a, logic [2:0] s,
                       logic [3:0] be, logic [31:0] wd, string tag);
    dq.push_back('{typ: t, wr: w, addr: a, size: s, be: be, wdata: wd});
    dtag.push_back(tag);
  endtask

  // Driver: queue the expected answer, then present the request.
  task automatic acc(bit wr, logic [31:0] a, logic [2:0] sz, logic [31:0] wd,
                     logic [31:0] exp, string tag);
    rq.push_back(exp);
    rtag.push_back(tag);
    @(negedge clk);
    up_write = wr; up_addr = a; up_size = sz; up_wdata = wd; up_valid = 1'b1;
    while (!up_ready) @(negedge clk);
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  // Answer monitor with throttled ready.
  initial begin
    int cyc;
    bit rr;
    logic [31:0] e;
    string t;
    cyc = 0;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      rr = (cyc % 3) != 1;
      rsp_ready = rr;
      if (rst_n && rsp_valid && rr) begin
        if (rq.size() == 0) chk(0, "R11 unexpected answer", 80'(rsp_rdata), 0);
        else begin
          e = rq.pop_front();
          t = rtag.pop_front();
          chk(rsp_rdata == e, t, 80'(rsp_rdata), 80'(e));
        end
      end
    end
  end

  // Downstream responder with varying acknowledge delay.
  initial begin
    dn_t got, e;
    string t;
    int dly;
    dly = 0;
    dn_ack = 1'b0;
    dn_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && dn_req) begin
        got = '{typ: dn_type, wr: dn_write, addr: dn_addr, size: dn_size, be: dn_be, wdata: dn_wdata};
        if (dq.size() == 0) chk(0, "R12 unexpected downstream cycle", 80'(got), 0);
        else begin
          e = dq.pop_front();
          t = dtag.pop_front();
          chk(got == e, t, 80'(got), 80'(e));
        end
        for (int k = 0; k < dly; k++) begin
          @(negedge clk);
          chk(dn_req && !up_ready && dn_addr == got.addr && dn_be == got.be &&
              dn_wdata == got.wdata, "R11 request held while waiting",
              80'(dn_addr), 80'(got.addr));
        end
        dly = (dly + 1) % 4;
        dn_rdata = pat(dn_addr);
        dn_ack = 1'b1;
        @(negedge clk);
        dn_ack = 1'b0;
        dn_rdata = '0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", rq.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(up_ready && !rsp_valid && !dn_req, "R11 reset outputs",
        80'({up_ready, rsp_valid, dn_req}), 80'(3'b100));

    // R1 reset header contents and read/write
    acc(0, 32'h1E20_0000, 3'd4, 0, {DID, VID}, "R1 id word");
    acc(0, 32'h1E20_0004, 3'd4, 0, 32'h0290_0080, "R1 command/status word");
    acc(1, 32'h1E20_00FC, 3'd4, 32'h1122_3344, 0, "R1 write last word");
    acc(0, 32'h1E20_00FC, 3'd4, 0, 32'h1122_3344, "R1 read last word");
    // R9 header alias
    acc(1, 32'hFE20_0010, 3'd4, 32'hA1B2_C3D4, 0, "R9 write via high alias");
    acc(0, 32'h1E20_0010, 3'd4, 0, 32'hA1B2_C3D4, "R9 read via low alias");

    // R2 configuration address
    acc(1, 32'h1E20_01C0, 3'd4, 32'h8000_1234, 0, "R2 write cfg address");
    acc(0, 32'hFE20_01C0, 3'd4, 0, 32'h8000_1234, "R2 read cfg address");

    // R3 write-only bases
    acc(1, 32'h1E20_01C4, 3'd4, 32'h4000_0000, 0, "R3 write mem base");
    acc(0, 32'h1E20_01C4, 3'd4, 0, 0, "R3 mem base reads zero");
    acc(1, 32'h1E20_01C8, 3'd4, 32'h0000_1000, 0, "R3 write io base");
    acc(0, 32'h1E20_01C8, 3'd4, 0, 0, "R3 io base reads zero");

    // R4 / R5 configuration port
    expdn(2'd0, 1, 32'h8000_1234, 3'd4, 4'hF, 32'hCAFE_F00D, "R4 cfg write request");
    acc(1, 32'h1E20_0220, 3'd4, 32'hCAFE_F00D, 0, "R4 cfg write answer");
    expdn(2'd0, 0, 32'h8000_1234, 3'd4, 4'hF, 32'h0, "R5 cfg read request");
    acc(0, 32'hFE20_0220, 3'd4, 0, pat(32'h8000_1234), "R5 cfg read data");

    // R6 ignored control accesses
    acc(1, 32'h1E20_01C0, 3'd1, 32'hFF, 0, "R6 byte write to cfg address");
    acc(0, 32'h1E20_0004, 3'd2, 0, 0, "R6 halfword header read");
    acc(1, 32'h1E20_0220, 3'd2, 32'h55, 0, "R6 halfword to cfg port");
    acc(1, 32'h1E20_0200, 3'd4, 32'h77, 0, "R6 write unused offset");
    acc(0, 32'h1E20_01CC, 3'd4, 0, 0, "R6 read unused offset");
    acc(0, 32'h1E20_01C0, 3'd4, 0, 32'h8000_1234, "R6 cfg address unchanged");

    // R7 / R10 memory window
    expdn(2'd1, 1, 32'h4000_0010, 3'd4, 4'hF, 32'hDEAD_BEEF, "R7 mem word write");
    acc(1, 32'h1D00_0010, 3'd4, 32'hDEAD_BEEF, 0, "R7 mem word write answer");
    expdn(2'd1, 0, 32'h4000_0013, 3'd1, 4'h8, 32'h0, "R10 mem byte read lane 3");
    acc(0, 32'h1D00_0013, 3'd1, 0, (pat(32'h4000_0013) >> 24) & 32'hFF, "R10 byte read data");
    expdn(2'd1, 1, 32'h4000_0102, 3'd2, 4'hC, 32'hBEEF_0000, "R10 mem half write upper");
    acc(1, 32'hFD00_0102, 3'd2, 32'h0000_BEEF, 0, "R9 mem half write via high alias");
    expdn(2'd1, 0, 32'h40FF_FFFC, 3'd4, 4'hF, 32'h0, "R7 last word of mem window");
    acc(0, 32'h1DFF_FFFC, 3'd4, 0, pat(32'h40FF_FFFC), "R7 mem word read data");

    // R8 / R10 I/O window
    expdn(2'd2, 0, 32'h0004_0FFC, 3'd4, 4'hF, 32'h0, "R8 last word of io window");
    acc(0, 32'h1E27_FFFC, 3'd4, 0, pat(32'h0004_0FFC), "R8 io word read data");
    expdn(2'd2, 1, 32'h0000_1001, 3'd1, 4'h2, 32'h0000_5A00, "R10 io byte write lane 1");
    acc(1, 32'hFE24_0001, 3'd1, 32'h0000_005A, 0, "R9 io write via high alias");
    expdn(2'd2, 0, 32'h0000_1002, 3'd2, 4'hC, 32'h0, "R10 io half read upper");
    acc(0, 32'h1E24_0002, 3'd2, 0, (pat(32'h0000_1002) >> 16) & 32'hFFFF, "R10 half read data");

    // R12 unmapped addresses and bad sizes
    acc(0, 32'h1E28_0000, 3'd4, 0, 0, "R12 just past io window");
    acc(1, 32'h1E00_0000, 3'd4, 32'h99, 0, "R12 just past mem window");
    acc(0, 32'h1E20_0224, 3'd4, 0, 0, "R12 just past control region");
    acc(1, 32'h1D00_0020, 3'd3, 32'h99, 0, "R12 size code 3 to mem window");
    acc(0, 32'h1E20_00FC, 3'd4, 0, 32'h1122_3344, "R12 header unchanged");

    for (int k = 0; k < 60 && rq.size() != 0; k++) @(negedge clk);
    chk(rq.size() == 0, "R11 all answers delivered", 80'(rq.size()), 0);
    chk(dq.size() == 0, "R11 all downstream cycles seen", 80'(dq.size()), 0);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule